// File: doc/BRIEF.md
# Interrupt Mask and Priority Register File

This block holds the mask and priority registers of an interrupt controller and turns every register write into per-source enable and disable events. A register can sit at one address, in which case a write replaces its contents. It can instead sit at a pair of addresses, one that sets bits and one that clears bits. Mask registers carry one bit per source. Priority registers carry a small multi-bit level per source.

On a write, the block compares the old and new contents of the register one field at a time. Only fields that changed raise an event. An event is an enable when the new field is nonzero and a disable when it is zero. A field can name a group entry rather than a real source. Such an entry passes its event down a fixed chain of member sources. A pending-logic stage downstream consumes the one-cycle event pulses.

Top module: `intc_mask_prio_regs`

## Requirements
- R1: After rst_ni is low, every register reads 0 and en_evt_o and dis_evt_o are all zero.
- R2: Only address bits 28:0 are compared, so a write or read with bits 31:29 set behaves like the same access with those bits clear.
- R3: A write to the set address of a register that has both a set address and a clear address ORs wdata_i into the register.
- R4: A write to the clear address of such a register clears the register bits where wdata_i is 1 and keeps all other bits.
- R5: A register that has only one address takes wdata_i unchanged.
- R6: A mask register has one 1-bit field per source. Bit REG_W-1 belongs to entry 0 of its source list, bit REG_W-2 to entry 1, and so on down. A bit of 1 enables its source and a bit of 0 disables it. With the defaults, mask 0 is dual at 0x40 (set) and 0x44 (clear) with sources 1,2,3,4,0,5,6,7. Mask 1 is single at 0x48 with sources 8,11,12,13,14,15,0,0.
- R7: A priority register has REG_W/FIELD_W fields of FIELD_W bits, and the top field belongs to entry 0. Any change in a field raises an event, including a change from one nonzero value to another. The event is an enable if the new value is nonzero and a disable if it is zero. With the defaults, the register is single at 0x50 with bits 7:4 for source 12 and bits 3:0 for source 2.
- R8: Events appear on the clock edge after the write edge and last one cycle. A field whose value did not change raises no event.
- R9: Source id 0 never produces an event. An entry with no vector and no chain link (default id 11) never produces an event.
- R10: An entry with no vector passes its event to its chain successor. From then on every member with a link passes it on, for up to HOPS members. An entry that has a vector and is written directly raises only its own event. Only ids with vectors ever pulse. With the defaults, ids 1–7, 9, 10, 12, 13 and 14 have vectors. The chain links are 8→9, 9→10, 12→13 and 15→14.
- R11: A read at either address of a register returns its stored value. A read of an unmapped address returns 0. A write to an unmapped address changes no register and raises no event.
- R12: When several fields of one write reach the same source, its enable and disable indications are each the OR of all contributions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 32 | Byte address for both reads and writes |
| wdata_i | input | REG_W | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | REG_W | Combinational read data for addr_i |
| en_evt_o | output | 2**SRC_W | Per-source enable pulse |
| dis_evt_o | output | 2**SRC_W | Per-source disable pulse |

## Verification
The single-address mask register and the priority register are each driven through all 256 values, in an odd-stride order so that successive writes flip many fields at once. This separates field-to-source mapping errors from change-detection errors, and it separates nonzero-to-nonzero priority changes from zero crossings. The dual mask register gets a pseudo-random sequence of set and clear writes, which tells OR from AND-NOT and replacement, with readback at both addresses. Directed writes cover the group chain, the reserved entry, colliding enable and disable on source 14, repeated values, aliased high address bits and unmapped accesses.

// File: rtl/intc_regs_pkg.sv
package intc_regs_pkg;
  localparam int unsigned ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t ADDR_KEEP = 32'h1FFF_FFFF;

  localparam int unsigned DEF_REG_W    = 8;
  localparam int unsigned DEF_FIELD_W  = 4;
  localparam int unsigned DEF_NUM_MASK = 2;
  localparam int unsigned DEF_NUM_PRIO = 1;
  localparam int unsigned DEF_SRC_W    = 4;
  localparam int unsigned DEF_HOPS     = 4;

  // address 0 means "not present"
  localparam logic [63:0] DEF_MASK_SET = {32'h0000_0048, 32'h0000_0040};
  localparam logic [63:0] DEF_MASK_CLR = {32'h0000_0000, 32'h0000_0044};
  localparam logic [31:0] DEF_PRIO_SET = 32'h0000_0050;
  localparam logic [31:0] DEF_PRIO_CLR = 32'h0000_0000;

  // entry e of register r at [(r*fields+e)*SRC_W +: SRC_W]; entry 0 = top field
  localparam logic [63:0] DEF_MASK_IDS = {32'h00FE_DCB8, 32'h7650_4321};
  localparam logic [7:0]  DEF_PRIO_IDS = 8'h2C;

  localparam logic [15:0] DEF_SRC_VECT = 16'h76FE;
  localparam logic [63:0] DEF_SRC_NEXT = 64'hE00D_00A9_0000_0000;
endpackage

// File: rtl/intc_addr_decode.sv
module intc_addr_decode
  import intc_regs_pkg::*;
#(
  parameter int unsigned NREG = 3,
  parameter logic [NREG*ADDR_W-1:0] SET_ADDR = '0,
  parameter logic [NREG*ADDR_W-1:0] CLR_ADDR = '0
) (
  input  addr_t           addr_i,
  output logic [NREG-1:0] hit_set_o,
  output logic [NREG-1:0] hit_clr_o,
  output logic            any_hit_o
);
  addr_t a_low;
  addr_t s_a, c_a;
  logic  found;

  always_comb begin
    a_low     = addr_i & ADDR_KEEP;
    hit_set_o = '0;
    hit_clr_o = '0;
    found     = 1'b0;
    s_a       = '0;
    c_a       = '0;
    for (int r = 0; r < int'(NREG); r++) begin
      s_a = SET_ADDR[r*ADDR_W +: ADDR_W];
      c_a = CLR_ADDR[r*ADDR_W +: ADDR_W];
      if (!found) begin
        if (s_a != '0 && a_low == (s_a & ADDR_KEEP)) begin
          hit_set_o[r] = 1'b1;
          found        = 1'b1;
        end else if (c_a != '0 && a_low == (c_a & ADDR_KEEP)) begin
          hit_clr_o[r] = 1'b1;
          found        = 1'b1;
        end
      end
    end
    any_hit_o = found;
  end
endmodule

// File: rtl/intc_reg_slice.sv
module intc_reg_slice #(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned FIELD_W = 1,
  parameter bit          DUAL    = 1'b0,
  localparam int unsigned NF     = REG_W / FIELD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             hit_set_i,
  input  logic             hit_clr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] value_o,
  output logic [NF-1:0]    chg_o,
  output logic [NF-1:0]    on_o
);
  logic [REG_W-1:0] value_q, value_d;
  logic             wr;

  assign wr = we_i && (hit_set_i || hit_clr_i);

  always_comb begin
    value_d = value_q;
    if (wr) begin
      if (DUAL) value_d = hit_set_i ? (value_q | wdata_i) : (value_q & ~wdata_i);
      else      value_d = wdata_i;
    end
  end

  for (genvar k = 0; k < NF; k++) begin : g_field
    localparam int unsigned LSB = (NF - 1 - k) * FIELD_W;
    assign chg_o[k] = value_q[LSB +: FIELD_W] != value_d[LSB +: FIELD_W];
    assign on_o[k]  = |value_d[LSB +: FIELD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) value_q <= '0;
    else         value_q <= value_d;
  end

  assign value_o = value_q;

  assert_dual_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DUAL && we_i && hit_set_i) |=>
      ((value_o & $past(wdata_i)) == $past(wdata_i)) &&
      ((value_o & ~$past(wdata_i)) == ($past(value_o) & ~$past(wdata_i))));

  assert_dual_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DUAL && we_i && hit_clr_i) |=>
      ((value_o & $past(wdata_i)) == '0) &&
      ((value_o & ~$past(wdata_i)) == ($past(value_o) & ~$past(wdata_i))));

  assert_direct_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!DUAL && we_i && (hit_set_i || hit_clr_i)) |=> value_o == $past(wdata_i));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (hit_set_i || hit_clr_i)) |=> $stable(value_o));
endmodule

// File: rtl/intc_chain_walk.sv
module intc_chain_walk #(
  parameter int unsigned SRC_W = 4,
  parameter int unsigned HOPS  = 4,
  localparam int unsigned NUM_SRC = 1 << SRC_W,
  parameter logic [NUM_SRC-1:0]       VECT = '0,
  parameter logic [NUM_SRC*SRC_W-1:0] NEXT = '0
) (
  input  logic               go_i,
  input  logic               on_i,
  input  logic [SRC_W-1:0]   id_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] dis_o
);
  logic [NUM_SRC-1:0] touched;
  logic [SRC_W-1:0]   cur, nxt;
  logic               live, grp;

  always_comb begin
    touched = '0;
    cur     = id_i;
    nxt     = '0;
    grp     = 1'b0;
    live    = go_i && (id_i != '0);
    for (int h = 0; h < int'(HOPS); h++) begin
      if (live) begin
        nxt = NEXT[cur*SRC_W +: SRC_W];
        if (!VECT[cur] && nxt == '0) begin
          live = 1'b0;  // reserved entry
        end else begin
          if (VECT[cur]) touched[cur] = 1'b1;
          if ((grp || !VECT[cur]) && nxt != '0) begin
            cur = nxt;
            grp = 1'b1;
          end else begin
            live = 1'b0;
          end
        end
      end
    end
  end

  assign en_o  = on_i ? touched : '0;
  assign dis_o = on_i ? '0 : touched;
endmodule

// File: rtl/intc_mask_prio_regs.sv
module intc_mask_prio_regs
  import intc_regs_pkg::*;
#(
  parameter int unsigned REG_W    = DEF_REG_W,
  parameter int unsigned FIELD_W  = DEF_FIELD_W,
  parameter int unsigned NUM_MASK = DEF_NUM_MASK,
  parameter int unsigned NUM_PRIO = DEF_NUM_PRIO,
  parameter int unsigned SRC_W    = DEF_SRC_W,
  parameter int unsigned HOPS     = DEF_HOPS,
  localparam int unsigned NUM_SRC = 1 << SRC_W,
  localparam int unsigned PRIO_NF = REG_W / FIELD_W,
  parameter logic [NUM_MASK*ADDR_W-1:0]        MASK_SET_ADDR = DEF_MASK_SET,
  parameter logic [NUM_MASK*ADDR_W-1:0]        MASK_CLR_ADDR = DEF_MASK_CLR,
  parameter logic [NUM_PRIO*ADDR_W-1:0]        PRIO_SET_ADDR = DEF_PRIO_SET,
  parameter logic [NUM_PRIO*ADDR_W-1:0]        PRIO_CLR_ADDR = DEF_PRIO_CLR,
  parameter logic [NUM_MASK*REG_W*SRC_W-1:0]   MASK_IDS      = DEF_MASK_IDS,
  parameter logic [NUM_PRIO*PRIO_NF*SRC_W-1:0] PRIO_IDS      = DEF_PRIO_IDS,
  parameter logic [NUM_SRC-1:0]                SRC_VECT      = DEF_SRC_VECT,
  parameter logic [NUM_SRC*SRC_W-1:0]          SRC_NEXT      = DEF_SRC_NEXT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               we_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic [NUM_SRC-1:0] en_evt_o,
  output logic [NUM_SRC-1:0] dis_evt_o
);
  localparam int unsigned NREG   = NUM_MASK + NUM_PRIO;
  localparam int unsigned M_FLDS = NUM_MASK * REG_W;
  localparam int unsigned P_FLDS = NUM_PRIO * PRIO_NF;
  localparam logic [NREG*ADDR_W-1:0] SET_ALL = {PRIO_SET_ADDR, MASK_SET_ADDR};
  localparam logic [NREG*ADDR_W-1:0] CLR_ALL = {PRIO_CLR_ADDR, MASK_CLR_ADDR};

  logic [NREG-1:0]    hit_set, hit_clr;
  logic               any_hit;
  logic [REG_W-1:0]   reg_val [NREG];
  logic [REG_W-1:0]   m_chg [NUM_MASK];
  logic [REG_W-1:0]   m_on  [NUM_MASK];
  logic [PRIO_NF-1:0] p_chg [NUM_PRIO];
  logic [PRIO_NF-1:0] p_on  [NUM_PRIO];
  logic [NUM_SRC-1:0] m_en [M_FLDS];
  logic [NUM_SRC-1:0] m_dis [M_FLDS];
  logic [NUM_SRC-1:0] p_en [P_FLDS];
  logic [NUM_SRC-1:0] p_dis [P_FLDS];
  logic [NUM_SRC-1:0] en_acc, dis_acc, en_q, dis_q;

  intc_addr_decode #(
    .NREG(NREG), .SET_ADDR(SET_ALL), .CLR_ADDR(CLR_ALL)
  ) u_dec (
    .addr_i(addr_i), .hit_set_o(hit_set), .hit_clr_o(hit_clr), .any_hit_o(any_hit)
  );

  for (genvar r = 0; r < NUM_MASK; r++) begin : g_mask
    localparam bit DUAL_M = (MASK_SET_ADDR[r*ADDR_W +: ADDR_W] != '0) &&
                            (MASK_CLR_ADDR[r*ADDR_W +: ADDR_W] != '0);
    intc_reg_slice #(.REG_W(REG_W), .FIELD_W(1), .DUAL(DUAL_M)) u_slice (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i),
      .hit_set_i(hit_set[r]), .hit_clr_i(hit_clr[r]), .wdata_i(wdata_i),
      .value_o(reg_val[r]), .chg_o(m_chg[r]), .on_o(m_on[r])
    );
    for (genvar k = 0; k < REG_W; k++) begin : g_fld
      localparam int unsigned IDX = r * REG_W + k;
      intc_chain_walk #(
        .SRC_W(SRC_W), .HOPS(HOPS), .VECT(SRC_VECT), .NEXT(SRC_NEXT)
      ) u_walk (
        .go_i(m_chg[r][k]), .on_i(m_on[r][k]),
        .id_i(MASK_IDS[IDX*SRC_W +: SRC_W]),
        .en_o(m_en[IDX]), .dis_o(m_dis[IDX])
      );
    end
  end

  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
    localparam bit DUAL_P = (PRIO_SET_ADDR[p*ADDR_W +: ADDR_W] != '0) &&
                            (PRIO_CLR_ADDR[p*ADDR_W +: ADDR_W] != '0);
    intc_reg_slice #(.REG_W(REG_W), .FIELD_W(FIELD_W), .DUAL(DUAL_P)) u_slice (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i),
      .hit_set_i(hit_set[NUM_MASK+p]), .hit_clr_i(hit_clr[NUM_MASK+p]),
      .wdata_i(wdata_i), .value_o(reg_val[NUM_MASK+p]),
      .chg_o(p_chg[p]), .on_o(p_on[p])
    );
    for (genvar k = 0; k < PRIO_NF; k++) begin : g_fld
      localparam int unsigned IDX = p * PRIO_NF + k;
      intc_chain_walk #(
        .SRC_W(SRC_W), .HOPS(HOPS), .VECT(SRC_VECT), .NEXT(SRC_NEXT)
      ) u_walk (
        .go_i(p_chg[p][k]), .on_i(p_on[p][k]),
        .id_i(PRIO_IDS[IDX*SRC_W +: SRC_W]),
        .en_o(p_en[IDX]), .dis_o(p_dis[IDX])
      );
    end
  end

  always_comb begin
    en_acc  = '0;
    dis_acc = '0;
    for (int i = 0; i < int'(M_FLDS); i++) begin
      en_acc  = en_acc  | m_en[i];
      dis_acc = dis_acc | m_dis[i];
    end
    for (int i = 0; i < int'(P_FLDS); i++) begin
      en_acc  = en_acc  | p_en[i];
      dis_acc = dis_acc | p_dis[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      dis_q <= '0;
    end else begin
      en_q  <= en_acc;
      dis_q <= dis_acc;
    end
  end

  assign en_evt_o  = en_q;
  assign dis_evt_o = dis_q;

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < int'(NREG); r++)
      if (hit_set[r] || hit_clr[r]) rdata_o = reg_val[r];
  end

  assert_no_evt_id0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_evt_o[0] && !dis_evt_o[0]);

  assert_evt_needs_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (en_evt_o == '0) && (dis_evt_o == '0));

  assert_evt_has_vector_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_evt_o | dis_evt_o) & ~SRC_VECT) == '0);

  assert_unmapped_read_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_hit |-> rdata_o == '0);
endmodule

// File: tb/intc_mask_prio_regs_tb.sv
`timescale 1ns/1ps
module intc_mask_prio_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] en_evt, dis_evt;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0]  shd [3];
  logic [15:0] exp_en, exp_dis;
  int m0_ids [8] = '{1, 2, 3, 4, 0, 5, 6, 7};
  int m1_ids [8] = '{8, 11, 12, 13, 14, 15, 0, 0};
  int p_ids  [2] = '{12, 2};

  always #2 clk = ~clk;

  intc_mask_prio_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .en_evt_o(en_evt), .dis_evt_o(dis_evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit has_vect(int id);
    return id inside {1, 2, 3, 4, 5, 6, 7, 9, 10, 12, 13, 14};
  endfunction

  function automatic int next_of(int id);
    case (id)
      8:  return 9;
      9:  return 10;
      12: return 13;
      15: return 14;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] walk(int id);
    logic [15:0] h = '0;
    int cur = id;
    bit grp = 0;
    if (cur == 0) return h;
    for (int k = 0; k < 4; k++) begin
      if (!has_vect(cur) && next_of(cur) == 0) break;
      if (has_vect(cur)) h[cur] = 1'b1;
      if ((grp || !has_vect(cur)) && next_of(cur) != 0) begin
        cur = next_of(cur);
        grp = 1;
      end else break;
    end
    return h;
  endfunction

  task automatic model(input int kind, input logic [7:0] o, input logic [7:0] n);
    logic [15:0] h;
    exp_en = '0;
    exp_dis = '0;
    if (kind < 2) begin
      for (int e = 0; e < 8; e++) begin
        if (o[7-e] != n[7-e]) begin
          h = walk(kind == 0 ? m0_ids[e] : m1_ids[e]);
          if (n[7-e]) exp_en |= h; else exp_dis |= h;
        end
      end
    end else begin
      for (int e = 0; e < 2; e++) begin
        if (o[(1-e)*4 +: 4] != n[(1-e)*4 +: 4]) begin
          h = walk(p_ids[e]);
          if (n[(1-e)*4 +: 4] != 0) exp_en |= h; else exp_dis |= h;
        end
      end
    end
  endtask

  // kind 0: dual mask, 1: single mask, 2: priority
  task automatic wr(input int kind, input logic [31:0] a, input logic [7:0] d,
                    input bit is_clr, input string tag);
    logic [7:0] nv;
    if (kind == 0) nv = is_clr ? (shd[0] & ~d) : (shd[0] | d);
    else           nv = d;
    model(kind, shd[kind], nv);
    shd[kind] = nv;
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk({tag, " en"}, {16'h0, en_evt}, {16'h0, exp_en});
    chk({tag, " dis"}, {16'h0, dis_evt}, {16'h0, exp_dis});
    @(negedge clk);
    chk("R8 pulse", {en_evt, dis_evt}, 32'h0);
    chk({tag, " read"}, {24'h0, rdata}, {24'h0, nv});
  endtask

  task automatic rd(input logic [31:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, {24'h0, rdata}, {24'h0, e});
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    shd[0] = '0; shd[1] = '0; shd[2] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd(32'h40, 8'h00, "R1 m0");
    rd(32'h48, 8'h00, "R1 m1");
    rd(32'h50, 8'h00, "R1 p0");
    chk("R1 events", {en_evt, dis_evt}, 32'h0);

    // R6 R5 R2 R9 R10 R12: full sweep of single-address mask
    for (int i = 0; i < 256; i++)
      wr(1, (i % 2 == 1) ? 32'hE000_0048 : 32'h0000_0048, 8'((i * 157 + 3) % 256), 0, "R6");

    // R7 R5 R2: full sweep of priority register
    for (int i = 0; i < 256; i++)
      wr(2, (i % 4 >= 2) ? 32'hA000_0050 : 32'h0000_0050, 8'((i * 83 + 7) % 256), 0, "R7");

    // R3 R4 R11: dual register set/clear sequence
    lf = 8'h5A;
    for (int i = 0; i < 128; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (i % 2 == 1) wr(0, (i % 8 >= 4) ? 32'h2000_0044 : 32'h44, lf, 1, "R4");
      else            wr(0, (i % 8 >= 4) ? 32'h2000_0040 : 32'h40, lf, 0, "R3");
      rd((i % 2 == 1) ? 32'h40 : 32'h44, shd[0], "R11 other addr");
    end

    // R12: source 14 reached twice with opposite sense
    wr(1, 32'h48, 8'h00, 0, "R12");
    wr(1, 32'h48, 8'h04, 0, "R12");
    wr(1, 32'h48, 8'h08, 0, "R12");
    // R8: same value again
    wr(1, 32'h48, 8'h08, 0, "R8");
    // R9: reserved id 11 (bit 6)
    wr(1, 32'h48, 8'h48, 0, "R9");
    // R9: id 0 slot of mask 0 (bit 3)
    wr(0, 32'h44, 8'hFF, 1, "R9");
    wr(0, 32'h40, 8'h08, 0, "R9");
    // R10: group 8 (bit 7) cascades to 9 and 10
    @(negedge clk);
    addr = 32'h48; wdata = 8'hC8; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk("R10 group en", {16'h0, en_evt}, 32'h0000_0600);
    chk("R10 group dis", {16'h0, dis_evt}, 32'h0);
    shd[1] = 8'hC8;

    // R11: unmapped write and read
    @(negedge clk);
    addr = 32'h4C; wdata = 8'hFF; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk("R11 unmapped events", {en_evt, dis_evt}, 32'h0);
    #1;
    chk("R11 unmapped read", {24'h0, rdata}, 32'h0);
    rd(32'h40, shd[0], "R11 m0 kept");
    rd(32'h48, shd[1], "R11 m1 kept");
    rd(32'h50, shd[2], "R11 p0 kept");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule